// File: doc/BRIEF.md
# Dual-Clock Read/Write Plus Read-Only RAM

This block is a synchronous word memory with two ports that run on unrelated clocks. The first port is clocked by `p1_clk`. On a given rising edge it either reads a word or writes a word. The second port is clocked by `p2_clk` and can only read. Each port has its own enable, and each port's read data comes from a register that updates on the edge after the access.

When the first port writes, its own read output shows the word just written. The second port shares only the storage array with the first port. A second-port read of a word that the first port is writing returns an undefined value. This holds from the write edge until, at worst, the next rising edge of `p1_clk`. Software and surrounding logic must keep such reads apart from writes.

A single active-low reset is asserted asynchronously. Its release is synchronised separately into each clock domain. While reset is low, it clears both read registers. The storage array is never reset.

Top module: `dual_clk_rw_ram`

## Requirements
- R1: The array holds 2**AW words of DW bits, with AW and DW as parameters. Every address from 0 to 2**AW-1 stores and returns its own word independently of all others.
- R2: On a rising edge of `p1_clk` with `p1_en`=1 and `p1_wen`=1, `p1_wdata` is stored at `p1_addr`.
- R3: On a rising edge of `p1_clk` with `p1_en`=1 and `p1_wen`=0, `p1_rdata` shows the word stored at `p1_addr`, starting in the cycle after that edge.
- R4: After a port-1 write edge, `p1_rdata` equals the data just written (write-first).
- R5: With `p1_en`=0, a `p1_clk` edge changes nothing, whatever `p1_wen` is: the addressed word is not written and `p1_rdata` keeps its value.
- R6: On a rising edge of `p2_clk` with `p2_en`=1, `p2_rdata` shows the word stored at `p2_addr`, starting in the cycle after that edge.
- R7: With `p2_en`=0, a `p2_clk` edge leaves `p2_rdata` unchanged.
- R8: While `rst_n`=0, `p1_rdata` and `p2_rdata` are 0. Each domain leaves reset two of its own clock edges after `rst_n` rises.
- R9: Port-2 reads of addresses that port 1 is not writing return correct data while port 1 writes other addresses at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| p1_clk | input | 1 | Port 1 clock |
| p1_en | input | 1 | Port 1 enable |
| p1_wen | input | 1 | Port 1 write select (1 = write, 0 = read) |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_rdata | output | DW | Port 1 registered read data |
| p2_clk | input | 1 | Port 2 clock |
| p2_en | input | 1 | Port 2 read enable |
| p2_addr | input | AW | Port 2 word address |
| p2_rdata | output | DW | Port 2 registered read data |

## Verification
The read-data assertions compare each output with the stored word one edge earlier. They therefore assume that every word read has already been written. They also assume that no port-2 read lands on an address that port 1 writes within the same write-clock window, since that value is undefined. The stimulus writes every address before any read. During concurrent activity, port 1 writes only the lower half of the array while port 2 reads only the upper half. Collisions therefore never occur, and every read can be compared against the bench's reference array.

// File: rtl/dcram_pkg.sv
package dcram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic acc_e decode_acc(input logic en, input logic wen);
    if (!en)     return ACC_IDLE;
    else if (wen) return ACC_WRITE;
    else         return ACC_READ;
  endfunction

endpackage

// File: rtl/dcram_rst_sync.sv
module dcram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_nxt;

  always_comb begin
    sr_nxt = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_nxt;
  end

  assign srst_n = sr_q[STAGES-1];

  // R8
  rst_follow_chk: assert property (@(posedge clk) !arst_n |-> !srst_n);

endmodule

// File: rtl/dcram_store.sv
module dcram_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rword_a,
  output logic [DW-1:0] rword_b
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rword_a = mem[raddr_a];
  assign rword_b = mem[raddr_b];

endmodule

// File: rtl/dcram_outreg.sv
module dcram_outreg
  import dcram_pkg::*;
#(
  parameter int DW          = 16,
  parameter bit WRITE_FIRST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rword,
  output logic [DW-1:0] q
);

  acc_e          acc;
  logic [DW-1:0] q_r;
  logic [DW-1:0] q_nxt;

  always_comb begin
    acc   = decode_acc(en, wen & WRITE_FIRST);
    q_nxt = q_r;
    case (acc)
      ACC_READ:  q_nxt = rword;
      ACC_WRITE: q_nxt = wdata;
      default:   q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  // R5 R7
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

  generate
    if (WRITE_FIRST) begin : g_wf
      // R4
      wf_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && wen |=> q == $past(wdata));
    end
  endgenerate

endmodule

// File: rtl/dual_clk_rw_ram.sv
module dual_clk_rw_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          rst_n,
  input  logic          p1_clk,
  input  logic          p1_en,
  input  logic          p1_wen,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic [DW-1:0] p1_rdata,
  input  logic          p2_clk,
  input  logic          p2_en,
  input  logic [AW-1:0] p2_addr,
  output logic [DW-1:0] p2_rdata
);

  logic          p1_rst_n;
  logic          p2_rst_n;
  logic          p1_we;
  logic [DW-1:0] p1_word;
  logic [DW-1:0] p2_word;

  assign p1_we = p1_en & p1_wen;

  dcram_rst_sync #(.STAGES(2)) u_rs1 (
    .clk(p1_clk), .arst_n(rst_n), .srst_n(p1_rst_n)
  );

  dcram_rst_sync #(.STAGES(2)) u_rs2 (
    .clk(p2_clk), .arst_n(rst_n), .srst_n(p2_rst_n)
  );

  dcram_store #(.AW(AW), .DW(DW)) u_store (
    .wclk    (p1_clk),
    .we      (p1_we),
    .waddr   (p1_addr),
    .wdata   (p1_wdata),
    .raddr_a (p1_addr),
    .raddr_b (p2_addr),
    .rword_a (p1_word),
    .rword_b (p2_word)
  );

  dcram_outreg #(.DW(DW), .WRITE_FIRST(1'b1)) u_q1 (
    .clk   (p1_clk),
    .rst_n (p1_rst_n),
    .en    (p1_en),
    .wen   (p1_wen),
    .wdata (p1_wdata),
    .rword (p1_word),
    .q     (p1_rdata)
  );

  dcram_outreg #(.DW(DW), .WRITE_FIRST(1'b0)) u_q2 (
    .clk   (p2_clk),
    .rst_n (p2_rst_n),
    .en    (p2_en),
    .wen   (1'b0),
    .wdata ('0),
    .rword (p2_word),
    .q     (p2_rdata)
  );

  // R3
  p1_read_chk: assert property (@(posedge p1_clk) disable iff (!p1_rst_n)
    p1_en && !p1_wen |=> p1_rdata == $past(p1_word));

  // R6
  p2_read_chk: assert property (@(posedge p2_clk) disable iff (!p2_rst_n)
    p2_en |=> p2_rdata == $past(p2_word));

endmodule

// File: tb/test_dual_clk_rw_ram.sv
module test_dual_clk_rw_ram;

  localparam int CLK_PERIOD  = 10;
  localparam int CLK2_PERIOD = 14;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          rst_n;
  logic          p1_clk = 1'b0;
  logic          p2_clk = 1'b0;
  logic          p1_en, p1_wen;
  logic [AW-1:0] p1_addr;
  logic [DW-1:0] p1_wdata;
  logic [DW-1:0] p1_rdata;
  logic          p2_en;
  logic [AW-1:0] p2_addr;
  logic [DW-1:0] p2_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #(CLK_PERIOD/2)  p1_clk = ~p1_clk;
  always #(CLK2_PERIOD/2) p2_clk = ~p2_clk;

  dual_clk_rw_ram #(.AW(AW), .DW(DW)) i_dual_clk_rw_ram (
    .rst_n(rst_n),
    .p1_clk(p1_clk), .p1_en(p1_en), .p1_wen(p1_wen), .p1_addr(p1_addr),
    .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .p2_clk(p2_clk), .p2_en(p2_en), .p2_addr(p2_addr), .p2_rdata(p2_rdata)
  );

  function automatic logic [DW-1:0] pat(input int a, input int pass);
    return DW'((a * 37 + pass * 11 + 5) & ((1 << DW) - 1));
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic p1_cycle(input logic en, input logic wen, input int a, input logic [DW-1:0] d);
    @(negedge p1_clk);
    p1_en = en; p1_wen = wen; p1_addr = AW'(a); p1_wdata = d;
    @(negedge p1_clk);
    p1_en = 1'b0; p1_wen = 1'b0;
  endtask

  task automatic p2_cycle(input logic en, input int a);
    @(negedge p2_clk);
    p2_en = en; p2_addr = AW'(a);
    @(negedge p2_clk);
    p2_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] held;
    rst_n = 1'b0;
    p1_en = 1'b0; p1_wen = 1'b0; p1_addr = '0; p1_wdata = '0;
    p2_en = 1'b0; p2_addr = '0;
    repeat (3) @(negedge p1_clk);
    check("R8 p1_rdata in reset", p1_rdata, '0);
    check("R8 p2_rdata in reset", p2_rdata, '0);
    rst_n = 1'b1;
    repeat (8) @(negedge p1_clk);

    // R2 R4: write every address, write-first output
    for (int a = 0; a < DEPTH; a++) begin
      p1_cycle(1'b1, 1'b1, a, pat(a, 0));
      ref_mem[a] = pat(a, 0);
      check("R4 write-first p1_rdata", p1_rdata, pat(a, 0));
    end

    // R1 R2 R3: read back every address on port 1, descending order
    for (int a = DEPTH - 1; a >= 0; a--) begin
      p1_cycle(1'b1, 1'b0, a, '0);
      check("R3 R1 p1 read", p1_rdata, ref_mem[a]);
    end

    // R5: disabled port 1 with write select high does nothing
    held = p1_rdata;
    p1_cycle(1'b0, 1'b1, 3, ~ref_mem[3]);
    check("R5 p1_rdata held", p1_rdata, held);
    p1_cycle(1'b1, 1'b0, 3, '0);
    check("R5 word not written", p1_rdata, ref_mem[3]);

    // R6 R1: port 2 reads every address
    for (int a = 0; a < DEPTH; a++) begin
      p2_cycle(1'b1, a);
      check("R6 R1 p2 read", p2_rdata, ref_mem[a]);
    end

    // R7: disabled port 2 holds
    held = p2_rdata;
    p2_cycle(1'b0, 2);
    check("R7 p2_rdata held", p2_rdata, held);

    // R9: concurrent, disjoint halves
    fork
      begin
        for (int a = 0; a < DEPTH/2; a++) begin
          p1_cycle(1'b1, 1'b1, a, pat(a, 1));
          ref_mem[a] = pat(a, 1);
          check("R4 concurrent write-first", p1_rdata, pat(a, 1));
        end
      end
      begin
        for (int a = DEPTH/2; a < DEPTH; a++) begin
          p2_cycle(1'b1, a);
          check("R9 p2 read during p1 writes", p2_rdata, ref_mem[a]);
        end
      end
    join

    for (int a = 0; a < DEPTH/2; a++) begin
      p2_cycle(1'b1, a);
      check("R9 R6 p2 sees new words", p2_rdata, pat(a, 1));
    end

    done = 1'b1;
    finish_run();
  end

endmodule